// File: doc/BRIEF.md
# Line Clamp Pulse Generator

This block produces one black-level clamp pulse per video line, timed in pixel clocks. It runs on the pixel clock. Its horizontal sync input is already synchronized to that clock and is active high. The block watches for the sync trailing edge, which is a registered high-to-low transition. It then waits a programmed number of pixel periods (the offset) and raises the clamp for a programmed number of pixel periods (the length). Offset and length are 8-bit counts. Both are captured at the trailing edge, so a new setting applies from the next line.

A select bit switches the block to an external source. When the select is set, the clamp output copies the external clamp input and the offset has no influence. The internal sequencer keeps running, but it no longer reaches the output.

Top module: `clamp_pulse_gen`

## Requirements
- R1: While rst_n is low, and after release until the first sync trailing edge, clamp_o is 0 in internal mode (ext_sel_i = 0).
- R2: With ext_sel_i = 1, clamp_o equals ext_clamp_i in the same cycle, whatever the offset and any sync activity.
- R3: In internal mode, if hsync_i is first sampled low at clock edge E0 after being high, clamp_o rises after edge E0+offset_i.
- R4: The internal clamp stays high for exactly length_i clock cycles and then returns low.
- R5: An offset_i of 0 is illegal, and the block treats it as 1: the clamp rises after edge E0+1.
- R6: A length_i of 0 produces no clamp pulse for that line.
- R7: A new sync trailing edge during the waiting phase or the pulse phase restarts the sequence. The clamp is low after the new E0 and rises after E0+offset.
- R8: A rising edge of hsync_i, or hsync_i held high, starts no clamp pulse.
- R9: Offset and length are captured at the trailing edge. Changing them later in the line does not alter the pulse of that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsync_i | input | 1 | Synchronized horizontal sync, active high |
| ext_clamp_i | input | 1 | External clamp source |
| ext_sel_i | input | 1 | 1 selects the external clamp, 0 selects internal timing |
| offset_i | input | 8 | Pixel periods from sync trailing edge to clamp start |
| length_i | input | 8 | Clamp width in pixel periods |
| clamp_o | output | 1 | Clamp pulse output |

## Verification
The assertions assume hsync_i is already synchronous to clk and changes only between clock edges. They also assume that a trailing edge needs at least one cycle of hsync_i high before it. The stimulus obeys both rules: it drives sync only on falling clock edges and always holds sync high for two full cycles before dropping it. Offset and length are also changed only on falling edges. Whenever the bench changes them during a line, it does so after the capturing edge has passed.

// File: rtl/clamp_pkg.sv
package clamp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_HOLD = 2'd2
    } clamp_state_e;

    typedef struct packed {
        logic sync;
    } sync_reg_t;

endpackage

// File: rtl/clamp_sync_edge.sv
module clamp_sync_edge
    import clamp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hsync_i,
    output logic fall_o
);

    sync_reg_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.sync = hsync_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // trailing edge: registered high, current sample low
    assign fall_o = r_q.sync & ~hsync_i;

    // a trailing edge can only last one cycle
    assert_fall_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);

    // a trailing edge requires sync to have been high
    assert_fall_needs_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |-> $past(hsync_i));

endmodule

// File: rtl/clamp_timer.sv
module clamp_timer
    import clamp_pkg::*;
#(
    parameter int CNT_W = 8
)
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall_i,
    input  logic [CNT_W-1:0] offset_i,
    input  logic [CNT_W-1:0] length_i,
    output logic             pulse_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        clamp_state_e     st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] len;
    } timer_reg_t;

    timer_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (fall_i) begin
            r_d.st  = ST_WAIT;
            r_d.cnt = (offset_i == '0) ? '0 : offset_i - ONE;
            r_d.len = length_i;
        end else begin
            unique case (r_q.st)
                ST_WAIT: begin
                    if (r_q.cnt == '0) begin
                        if (r_q.len == '0) begin
                            r_d.st = ST_IDLE;
                        end else begin
                            r_d.st  = ST_HOLD;
                            r_d.cnt = r_q.len - ONE;
                        end
                    end else begin
                        r_d.cnt = r_q.cnt - ONE;
                    end
                end
                ST_HOLD: begin
                    if (r_q.cnt == '0) r_d.st = ST_IDLE;
                    else               r_d.cnt = r_q.cnt - ONE;
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, cnt: '0, len: '0};
        else        r_q <= r_d;
    end

    assign pulse_o = (r_q.st == ST_HOLD);

    assert_edge_restarts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fall_i |=> (r_q.st == ST_WAIT));

    assert_zero_offset_as_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_i && offset_i == '0) |=> (r_q.st == ST_WAIT && r_q.cnt == '0));

    assert_hold_within_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_HOLD) |-> (r_q.cnt < r_q.len));

    assert_zero_length_no_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WAIT && r_q.cnt == '0 && r_q.len == '0 && !fall_i)
        |=> (r_q.st == ST_IDLE));

    assert_length_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_i |=> $stable(r_q.len));

    assert_wait_leads_to_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WAIT && r_q.cnt == '0 && r_q.len != '0 && !fall_i)
        |=> pulse_o);

endmodule

// File: rtl/clamp_out_sel.sv
module clamp_out_sel (
    input  logic ext_sel_i,
    input  logic ext_clamp_i,
    input  logic pulse_i,
    output logic clamp_o
);

    always_comb begin
        clamp_o = ext_sel_i ? ext_clamp_i : pulse_i;
    end

endmodule

// File: rtl/clamp_pulse_gen.sv
module clamp_pulse_gen #(
    parameter int CNT_W = 8
)
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync_i,
    input  logic             ext_clamp_i,
    input  logic             ext_sel_i,
    input  logic [CNT_W-1:0] offset_i,
    input  logic [CNT_W-1:0] length_i,
    output logic             clamp_o
);

    logic fall;
    logic pulse;

    clamp_sync_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .hsync_i (hsync_i),
        .fall_o  (fall)
    );

    clamp_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .fall_i   (fall),
        .offset_i (offset_i),
        .length_i (length_i),
        .pulse_o  (pulse)
    );

    clamp_out_sel u_sel (
        .ext_sel_i   (ext_sel_i),
        .ext_clamp_i (ext_clamp_i),
        .pulse_i     (pulse),
        .clamp_o     (clamp_o)
    );

    // the first cycle after a trailing edge is always in the waiting phase
    assert_no_clamp_after_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !pulse);

endmodule

// File: tb/clamp_pulse_gen_test.sv
`timescale 1ns/1ps
module clamp_pulse_gen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsync_i = 1'b0;
    logic       ext_clamp_i = 1'b0;
    logic       ext_sel_i = 1'b0;
    logic [7:0] offset_i = 8'd1;
    logic [7:0] length_i = 8'd1;
    logic       clamp_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    clamp_pulse_gen uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .hsync_i     (hsync_i),
        .ext_clamp_i (ext_clamp_i),
        .ext_sel_i   (ext_sel_i),
        .offset_i    (offset_i),
        .length_i    (length_i),
        .clamp_o     (clamp_o)
    );

    // {offset, length, expected start, expected length}
    localparam logic [31:0] VEC [0:6] = '{
        32'h01010101,
        32'h05030503,
        32'h11281128,
        32'hFF02FF02,
        32'h00040104,
        32'h08000800,
        32'h02FF02FF
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_fall();
        @(negedge clk) hsync_i = 1'b1;
        @(negedge clk);
        @(negedge clk) hsync_i = 1'b0;
    endtask

    // first sample is taken after the capturing edge E0; k counts edges past E0
    task automatic measure(input logic [7:0] np, input logic [7:0] nl,
                           output int start, output int len);
        start = -1;
        len = 0;
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            if (k == 0) begin
                offset_i = np;
                length_i = nl;
            end
            if (clamp_o) begin
                if (start < 0) start = k;
                len++;
            end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int st, ln, hi, mism;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 clamp during reset", int'(clamp_o), 0);
        rst_n = 1'b1;
        hi = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (clamp_o) hi++;
        end
        check("R1 clamp idle after reset", hi, 0);

        // R3/R4/R5/R6: vector table
        for (int i = 0; i < 7; i++) begin
            offset_i = VEC[i][31:24];
            length_i = VEC[i][23:16];
            do_fall();
            measure(VEC[i][31:24], VEC[i][23:16], st, ln);
            if (VEC[i][7:0] != 0)
                check($sformatf("R3 R5 start vec%0d", i), st, int'(VEC[i][15:8]));
            check($sformatf("R4 R6 length vec%0d", i), ln, int'(VEC[i][7:0]));
        end

        // R9: change settings after capture
        offset_i = 8'd4;
        length_i = 8'd3;
        do_fall();
        measure(8'd50, 8'd9, st, ln);
        check("R9 start unchanged", st, 4);
        check("R9 length unchanged", ln, 3);
        do_fall();
        measure(8'd50, 8'd9, st, ln);
        check("R9 next line start", st, 50);
        check("R9 next line length", ln, 9);

        // R7: restart during waiting phase
        offset_i = 8'd10;
        length_i = 8'd5;
        do_fall();
        hi = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (clamp_o) hi++;
        end
        check("R7 no clamp before restart", hi, 0);
        do_fall();
        measure(8'd10, 8'd5, st, ln);
        check("R7 restart in wait start", st, 10);
        check("R7 restart in wait length", ln, 5);

        // R7: restart during pulse
        offset_i = 8'd3;
        length_i = 8'd20;
        do_fall();
        repeat (8) @(negedge clk);
        check("R7 in pulse before restart", int'(clamp_o), 1);
        do_fall();
        measure(8'd3, 8'd20, st, ln);
        check("R7 restart in pulse start", st, 3);
        check("R7 restart in pulse length", ln, 20);

        // R8: rising edge and high level start nothing
        offset_i = 8'd2;
        length_i = 8'd3;
        @(negedge clk) hsync_i = 1'b1;
        hi = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (clamp_o) hi++;
        end
        check("R8 no clamp on rise or high", hi, 0);
        hsync_i = 1'b0;
        repeat (20) @(negedge clk);

        // R2: external source
        ext_sel_i = 1'b1;
        offset_i = 8'd2;
        length_i = 8'd3;
        do_fall();
        mism = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            ext_clamp_i = ((k % 3) == 1);
            #1;
            if (clamp_o !== ext_clamp_i) mism++;
        end
        check("R2 external passthrough mismatches", mism, 0);
        ext_clamp_i = 1'b1;
        #1;
        check("R2 external high", int'(clamp_o), 1);
        ext_clamp_i = 1'b0;
        #1;
        check("R2 external low", int'(clamp_o), 0);
        ext_sel_i = 1'b0;
        repeat (10) @(negedge clk);
        check("R2 back to internal idle", int'(clamp_o), 0);

        finish_run();
    end

endmodule